// File: doc/BRIEF.md
# Multi-Queue Descriptor Store with Occupancy Vector

This block keeps packet buffer descriptors in a set of independent first-in first-out queues. The payload buffers themselves live elsewhere; each queue entry is only a short handle to one such buffer. A producer names a queue and offers a descriptor. A consumer names a queue and receives the oldest descriptor held there. One producer and one consumer operation may be requested in every clock cycle, and they may target the same queue.

A scheduler can read the state of all queues in one access. It sees a vector with one bit per queue, set while that queue holds anything. A count port returns the exact fill of one selected queue. Each queue also has a nearly-full flag, compared against a programmable threshold. Enqueues that reach the threshold are refused and reported as drops, so upstream logic discards packets before a queue overflows.

Two misuses are latched as sticky, write-one-to-clear error bits: a push into a completely full queue, and a pop from an empty queue. Each bit is stored with the identity of the requester, so a processor can poll for faults instead of servicing an interrupt. Every decision in a cycle uses the counts held at the start of that cycle.

Top module: `dq_manager`

## Requirements
- R1: An enqueue to a queue whose index is below NUM_Q is accepted when its count is below both DEPTH and `thresh`. The cycle after acceptance, `enq_ack` is 1 and that queue's count is one higher.
- R2: A dequeue from a non-empty queue gives `deq_ok` = 1 one cycle after the request, with the oldest descriptor of that queue on `deq_desc`. Each queue keeps first-in first-out order, independently of the others.
- R3: Bit q of `occ_vec` is 1 exactly when queue q holds at least one descriptor. It reflects the operations of the previous edge.
- R4: `cnt_out` shows the count that queue `cnt_qid` held at the start of the cycle in which `cnt_qid` was sampled. It reads 0 for an index of NUM_Q or more.
- R5: Bit q of `nfull_vec` is 1 when queue q's count is at least `thresh`. Every enqueue that is not accepted gives `enq_drop` = 1 the next cycle and leaves all counts and contents unchanged. This covers a queue at the threshold, a full queue and an index out of range.
- R6: An enqueue to a valid queue that already holds DEPTH descriptors sets `err_flags[0]` and loads `ovf_src` with `enq_src`. The queue is left unchanged.
- R7: A dequeue from a valid, empty queue sets `err_flags[1]` and loads `und_src` with `deq_src`. It gives no `deq_ok`, and no queue changes.
- R8: An enqueue and a dequeue to the same queue in one cycle are each judged on the count at the start of the cycle. When both succeed, the count is unchanged and order is kept. A pop from an empty queue fails even though a push to it succeeds in the same cycle.
- R9: Error bits stay set until a 1 is written to the matching bit of `err_clr`. An event arriving in the same cycle as its clear leaves the bit set.
- R10: While `rst` is high, all counts, `occ_vec`, `nfull_vec`, the pulse outputs, `cnt_out` and the error bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request |
| enq_qid | input | QW | Target queue of the enqueue |
| enq_src | input | SRC_W | Identity of the producer |
| enq_desc | input | DW | Descriptor to store |
| deq_valid | input | 1 | Dequeue request |
| deq_qid | input | QW | Source queue of the dequeue |
| deq_src | input | SRC_W | Identity of the consumer |
| thresh | input | CW | Nearly-full threshold, 0 to 2*DEPTH-1 |
| cnt_qid | input | QW | Queue whose count is reported |
| err_clr | input | 2 | Write-one-to-clear for `err_flags` |
| enq_ack | output | 1 | Enqueue of the previous cycle accepted |
| enq_drop | output | 1 | Enqueue of the previous cycle refused |
| deq_ok | output | 1 | Dequeue of the previous cycle succeeded |
| deq_desc | output | DW | Descriptor returned, valid with `deq_ok` |
| occ_vec | output | NUM_Q | One bit per queue, 1 = non-empty |
| nfull_vec | output | NUM_Q | One bit per queue, 1 = count at or above `thresh` |
| cnt_out | output | CW | Count of the selected queue |
| err_flags | output | 2 | Bit 0 push into full queue, bit 1 pop from empty queue |
| ovf_src | output | SRC_W | Requester of the latest push into a full queue |
| und_src | output | SRC_W | Requester of the latest pop from an empty queue |

## Verification
The bench builds the block with its defaults: 11 queues of 16 entries, 16-bit descriptors and 4-bit requester tags. The queue count is not a power of two, so a 4-bit queue index can name indices 11 to 15. That makes the out-of-range drop path and the zero count reading reachable. A depth of 16 is small enough that directed runs and random traffic both drive queues to completely full when the threshold is 16 or more. Thresholds of 3 and 8 exercise early drop without an error, and a threshold of 0 refuses everything.

// File: rtl/dq_pkg.sv
package dq_pkg;
  // positions inside err_flags / err_clr
  localparam int unsigned ERR_FULL_PUSH = 0;
  localparam int unsigned ERR_EMPTY_POP = 1;
  localparam int unsigned ERR_KINDS     = 2;
endpackage

// File: rtl/dq_slot.sv
module dq_slot #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] thresh,
  output logic [CW-1:0] cnt,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic          occ,
  output logic          nfull
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    unique case ({push, pop})
      2'b10:   cnt_nxt = cnt + CW'(1);
      2'b01:   cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      head  <= '0;
      tail  <= '0;
      occ   <= 1'b0;
      nfull <= 1'b0;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (pop)  head <= head + PW'(1);
      cnt   <= cnt_nxt;
      occ   <= (cnt_nxt != '0);
      nfull <= (cnt_nxt >= thresh);
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_push_room_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(DEPTH)));
  p_pop_data_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
  p_pair_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(cnt));
  p_ptr_gap_r2: assert property (@(posedge clk) disable iff (rst)
    PW'(tail - head) == cnt[PW-1:0]);
endmodule

// File: rtl/dq_store.sv
module dq_store #(
  parameter int unsigned DW      = 16,
  parameter int unsigned ENTRIES = 176,
  parameter int unsigned AW      = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:ENTRIES-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dq_errlog.sv
module dq_errlog
  import dq_pkg::*;
#(
  parameter int unsigned SRC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 full_evt,
  input  logic [SRC_W-1:0]     full_who,
  input  logic                 empty_evt,
  input  logic [SRC_W-1:0]     empty_who,
  input  logic [ERR_KINDS-1:0] clr,
  output logic [ERR_KINDS-1:0] flags,
  output logic [SRC_W-1:0]     full_src,
  output logic [SRC_W-1:0]     empty_src
);
  logic [ERR_KINDS-1:0] evt;
  assign evt[ERR_FULL_PUSH] = full_evt;
  assign evt[ERR_EMPTY_POP] = empty_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      full_src  <= '0;
      empty_src <= '0;
    end else begin
      flags <= (flags & ~clr) | evt;
      if (full_evt)  full_src  <= full_who;
      if (empty_evt) empty_src <= empty_who;
    end
  end

  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (flags[ERR_FULL_PUSH] && !clr[ERR_FULL_PUSH]) |=> flags[ERR_FULL_PUSH]);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    full_evt |=> flags[ERR_FULL_PUSH]);
  p_empty_set_r7: assert property (@(posedge clk) disable iff (rst)
    empty_evt |=> (flags[ERR_EMPTY_POP] && empty_src == $past(empty_who)));
endmodule

// File: rtl/dq_manager.sv
module dq_manager
  import dq_pkg::*;
#(
  parameter int unsigned NUM_Q = 11,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned SRC_W = 4,
  localparam int unsigned QW   = $clog2(NUM_Q),
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enq_valid,
  input  logic [QW-1:0]        enq_qid,
  input  logic [SRC_W-1:0]     enq_src,
  input  logic [DW-1:0]        enq_desc,
  input  logic                 deq_valid,
  input  logic [QW-1:0]        deq_qid,
  input  logic [SRC_W-1:0]     deq_src,
  input  logic [CW-1:0]        thresh,
  input  logic [QW-1:0]        cnt_qid,
  input  logic [ERR_KINDS-1:0] err_clr,
  output logic                 enq_ack,
  output logic                 enq_drop,
  output logic                 deq_ok,
  output logic [DW-1:0]        deq_desc,
  output logic [NUM_Q-1:0]     occ_vec,
  output logic [NUM_Q-1:0]     nfull_vec,
  output logic [CW-1:0]        cnt_out,
  output logic [ERR_KINDS-1:0] err_flags,
  output logic [SRC_W-1:0]     ovf_src,
  output logic [SRC_W-1:0]     und_src
);
  localparam int unsigned AW      = QW + PW;
  localparam int unsigned ENTRIES = NUM_Q * DEPTH;

  logic [CW-1:0] cnt_a  [NUM_Q];
  logic [PW-1:0] head_a [NUM_Q];
  logic [PW-1:0] tail_a [NUM_Q];
  logic [NUM_Q-1:0] push_v, pop_v;

  logic [CW-1:0] enq_cnt, deq_cnt, sel_cnt;
  logic [PW-1:0] enq_tail, deq_head;
  logic enq_qok, deq_qok, enq_take, enq_full_hit, deq_take, deq_empty_hit;

  always_comb begin
    enq_cnt  = '0;
    deq_cnt  = '0;
    sel_cnt  = '0;
    enq_tail = '0;
    deq_head = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (enq_qid == QW'(i)) begin
        enq_cnt  = cnt_a[i];
        enq_tail = tail_a[i];
      end
      if (deq_qid == QW'(i)) begin
        deq_cnt  = cnt_a[i];
        deq_head = head_a[i];
      end
      if (cnt_qid == QW'(i)) sel_cnt = cnt_a[i];
    end
  end

  assign enq_qok       = (enq_qid < QW'(NUM_Q));
  assign deq_qok       = (deq_qid < QW'(NUM_Q));
  assign enq_full_hit  = enq_valid && enq_qok && (enq_cnt == CW'(DEPTH));
  assign enq_take      = enq_valid && enq_qok && (enq_cnt != CW'(DEPTH))
                         && (enq_cnt < thresh);
  assign deq_take      = deq_valid && deq_qok && (deq_cnt != '0);
  assign deq_empty_hit = deq_valid && deq_qok && (deq_cnt == '0);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign push_v[q] = enq_take && (enq_qid == QW'(q));
    assign pop_v[q]  = deq_take && (deq_qid == QW'(q));

    dq_slot #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) i_slot (
      .clk    (clk),
      .rst    (rst),
      .push   (push_v[q]),
      .pop    (pop_v[q]),
      .thresh (thresh),
      .cnt    (cnt_a[q]),
      .head   (head_a[q]),
      .tail   (tail_a[q]),
      .occ    (occ_vec[q]),
      .nfull  (nfull_vec[q])
    );
  end

  dq_store #(.DW(DW), .ENTRIES(ENTRIES), .AW(AW)) i_store (
    .clk   (clk),
    .we    (enq_take),
    .waddr ({enq_qid, enq_tail}),
    .wdata (enq_desc),
    .re    (deq_take),
    .raddr ({deq_qid, deq_head}),
    .rdata (deq_desc)
  );

  dq_errlog #(.SRC_W(SRC_W)) i_err (
    .clk       (clk),
    .rst       (rst),
    .full_evt  (enq_full_hit),
    .full_who  (enq_src),
    .empty_evt (deq_empty_hit),
    .empty_who (deq_src),
    .clr       (err_clr),
    .flags     (err_flags),
    .full_src  (ovf_src),
    .empty_src (und_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enq_ack  <= 1'b0;
      enq_drop <= 1'b0;
      deq_ok   <= 1'b0;
      cnt_out  <= '0;
    end else begin
      enq_ack  <= enq_take;
      enq_drop <= enq_valid && !enq_take;
      deq_ok   <= deq_take;
      cnt_out  <= sel_cnt;
    end
  end

  p_ack_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(enq_ack && enq_drop));
  p_deq_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    deq_ok |-> ($past(occ_vec) != '0));
  p_full_flags_r5: assert property (@(posedge clk) disable iff (rst)
    enq_full_hit |=> enq_drop);
endmodule

// File: tb/test_dq_manager.sv
`timescale 1ns/1ps
module test_dq_manager;
  localparam int NQ = 11, DP = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic enq_valid = 0, deq_valid = 0;
  logic [3:0] enq_qid = 0, deq_qid = 0, cnt_qid = 0, enq_src = 0, deq_src = 0;
  logic [15:0] enq_desc = 0;
  logic [4:0] thresh = 5'd16;
  logic [1:0] err_clr = 0;
  logic enq_ack, enq_drop, deq_ok;
  logic [15:0] deq_desc;
  logic [10:0] occ_vec, nfull_vec;
  logic [4:0] cnt_out;
  logic [1:0] err_flags;
  logic [3:0] ovf_src, und_src;

  always #2.5 clk = ~clk;

  dq_manager i_dq_manager (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_qid(enq_qid),
    .enq_src(enq_src), .enq_desc(enq_desc), .deq_valid(deq_valid),
    .deq_qid(deq_qid), .deq_src(deq_src), .thresh(thresh), .cnt_qid(cnt_qid),
    .err_clr(err_clr), .enq_ack(enq_ack), .enq_drop(enq_drop), .deq_ok(deq_ok),
    .deq_desc(deq_desc), .occ_vec(occ_vec), .nfull_vec(nfull_vec),
    .cnt_out(cnt_out), .err_flags(err_flags), .ovf_src(ovf_src), .und_src(und_src)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] mq [NQ][$];
  logic [1:0] m_flags = 0;
  logic [3:0] m_ovf = 0, m_und = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus, model update and full comparison
  task automatic step();
    bit e_ack = 0, e_drop = 0, e_dok = 0, ev_o = 0, ev_u = 0;
    logic [15:0] e_data = 0;
    logic [10:0] e_occ = 0, e_nf = 0;
    int e_cnt, eq, dq;
    eq = int'(enq_qid);
    dq = int'(deq_qid);
    if (enq_valid) begin
      if (eq < NQ && mq[eq].size() < DP && mq[eq].size() < int'(thresh)) e_ack = 1;
      else begin
        e_drop = 1;
        if (eq < NQ && mq[eq].size() == DP) ev_o = 1;
      end
    end
    if (deq_valid && dq < NQ) begin
      if (mq[dq].size() > 0) begin e_dok = 1; e_data = mq[dq][0]; end
      else ev_u = 1;
    end
    e_cnt = (int'(cnt_qid) < NQ) ? mq[int'(cnt_qid)].size() : 0;
    m_flags = (m_flags & ~err_clr) | {ev_u, ev_o};
    if (ev_o) m_ovf = enq_src;
    if (ev_u) m_und = deq_src;
    if (e_dok) void'(mq[dq].pop_front());
    if (e_ack) mq[eq].push_back(enq_desc);
    for (int q = 0; q < NQ; q++) begin
      e_occ[q] = mq[q].size() != 0;
      e_nf[q]  = mq[q].size() >= int'(thresh);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1 enq_ack", enq_ack, e_ack);
    chk("R5 enq_drop", enq_drop, e_drop);
    chk("R2 deq_ok", deq_ok, e_dok);
    if (e_dok) chk("R2 deq_desc order", deq_desc, e_data);
    chk("R3 occ_vec", occ_vec, e_occ);
    chk("R4 cnt_out", cnt_out, e_cnt);
    chk("R5 nfull_vec", nfull_vec, e_nf);
    chk("R6/R7/R9 err_flags", err_flags, m_flags);
    chk("R6 ovf_src", ovf_src, m_ovf);
    chk("R7 und_src", und_src, m_und);
  endtask

  task automatic idle();
    enq_valid = 0; deq_valid = 0; err_clr = 0;
  endtask

  task automatic enq(int q, int d, int s);
    idle(); enq_valid = 1; enq_qid = 4'(q); enq_desc = 16'(d); enq_src = 4'(s);
    step();
  endtask

  task automatic deq(int q, int s);
    idle(); deq_valid = 1; deq_qid = 4'(q); deq_src = 4'(s);
    step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 occ_vec", occ_vec, 0);
    chk("R10 nfull_vec", nfull_vec, 0);
    chk("R10 err_flags", err_flags, 0);
    chk("R10 pulses", {enq_ack, enq_drop, deq_ok}, 0);
    chk("R10 cnt_out", cnt_out, 0);
    rst = 0;
    idle(); step();

    // R1/R2: interleaved traffic on three queues
    for (int i = 0; i < 3; i++) begin
      enq(0, 16'h1000 + i, 1);
      enq(3, 16'h3000 + i, 2);
      enq(10, 16'hA000 + i, 3);
    end
    cnt_qid = 3; idle(); step(); step();
    for (int i = 0; i < 3; i++) begin deq(10, 4); deq(0, 5); end
    deq(3, 6);

    // R6: fill queue 2 to DEPTH, then push again
    cnt_qid = 2;
    for (int i = 0; i < DP; i++) enq(2, 16'h2200 + i, 7);
    enq(2, 16'hDEAD, 9);
    idle(); step();
    chk("R6 full count kept", cnt_out, DP);

    // R7: pop an empty queue
    deq(5, 12);
    // R9: clear while a new overflow arrives; then clear empty-pop bit alone
    idle(); enq_valid = 1; enq_qid = 2; enq_src = 4'hB; err_clr = 2'b11; step();
    chk("R9 set wins", err_flags, 2'b01);
    idle(); err_clr = 2'b01; step();
    chk("R9 cleared", err_flags, 2'b00);

    // R5: early drop at threshold 4
    thresh = 5'd4; cnt_qid = 7;
    for (int i = 0; i < 5; i++) enq(7, 16'h7700 + i, 1);
    idle(); step();
    chk("R5 no error on drop", err_flags, 0);
    chk("R5 count held", cnt_out, 4);
    enq(13, 16'h1313, 2); // out-of-range index
    thresh = 5'd16;

    // R8: simultaneous pair on a queue holding 2
    enq(4, 16'h4400, 1); enq(4, 16'h4401, 1);
    idle(); enq_valid = 1; enq_qid = 4; enq_desc = 16'h4402;
    deq_valid = 1; deq_qid = 4; cnt_qid = 4; step();
    idle(); step();
    chk("R8 count unchanged", cnt_out, 2);
    // R8: pair on an empty queue: pop fails, push succeeds
    idle(); enq_valid = 1; enq_qid = 6; enq_desc = 16'h6600;
    deq_valid = 1; deq_qid = 6; deq_src = 4'h3; step();
    // R8: pair on a full queue: push refused, pop succeeds
    idle(); deq_valid = 1; deq_qid = 2; enq_valid = 1; enq_qid = 2; step();
    for (int i = 0; i < 3; i++) deq(4, 1);

    // random traffic with varying thresholds
    for (int i = 0; i < 3000; i++) begin
      idle();
      enq_valid = ($urandom % 10) < 6;
      enq_qid = 4'($urandom % 12);
      enq_desc = 16'($urandom);
      enq_src = 4'($urandom);
      deq_valid = ($urandom % 100) < 45;
      deq_qid = 4'($urandom % 12);
      deq_src = 4'($urandom);
      cnt_qid = 4'($urandom % 16);
      if ($urandom % 20 == 0) err_clr = 2'($urandom);
      if ($urandom % 200 == 0) begin
        case ($urandom % 5)
          0: thresh = 5'd3;
          1: thresh = 5'd8;
          2: thresh = 5'd20;
          3: thresh = 5'd0;
          default: thresh = 5'd16;
        endcase
      end
      step();
    end
    summary();
    $finish;
  end
endmodule